// File: doc/BRIEF.md
# Mixed Text and Bitmap Scanline Renderer

This block turns a display-side video memory into a 640×480, 60 Hz VGA picture. It runs on the pixel clock and reads one byte per visible pixel from a synchronous memory. It then drives active-low horizontal and vertical sync and a 6-bit colour bus (2 bits each for red, green and blue). The screen is cut into horizontal bands 16 scanlines tall. Each band shows one of two things. The first is monochrome text: 80 columns of 8×16 glyphs drawn from an internal font table. The second is a 160×120 colour bitmap in which every source pixel covers a 4×4 block of screen pixels.

The rendering mode for each band comes from a control byte held in the same memory as the text. That byte sits in a text column that is never drawn. The renderer reads it during horizontal blanking on the scanline just before the band starts, and keeps it for all 16 lines of the band. Text cells and bitmap pixels use interleaved address maps within one 64 KiB space. Software can therefore mix status text and graphics on one screen.

The memory port is a plain request with a fixed latency of one cycle and no back-pressure. Every request made with `mem_rd_en_o` high must be answered on `mem_rdata_i` on the next cycle, because the pixel stream cannot stall. The colour and sync outputs are plain video-timing pins and have no handshake. The number of text columns and rows and all blanking widths are parameters. The defaults give standard VGA timing.

Top module: `vga_mixed_renderer`

## Requirements
- R1: Each line is H_VIS+H_FP+H_SYNC+H_BP cycles long and each frame is V_VIS+V_FP+V_SYNC+V_BP lines long. `hsync_o` is low for H_SYNC cycles beginning H_VIS+H_FP cycles into the line. `vsync_o` is low for V_SYNC lines beginning V_VIS+V_FP lines into the frame. Both signals are otherwise high.
- R2: While reset is held, `hsync_o` and `vsync_o` are 1, `rgb_o` is 0 and every band mode is text. After reset the scan position starts at pixel 0, line 0, and the sync and colour for any position appear exactly 2 cycles after the scan reaches that position.
- R3: In a text band, the character code for pixel (h, v) is read at address {3'b111, (v/16) as 6 bits, (h/8) as 7 bits}. The glyph row is v mod 16 and the glyph bit is h mod 8, taken MSB first (bit 7 is the leftmost pixel). A set bit gives `rgb_o` = 6'h3F and a clear bit gives 0.
- R4: In an image band, the byte for pixel (h, v) is read at address {1'b1, (h/4) as 8 bits, (v/4) as 7 bits}. `rgb_o` equals bits 5:0 of that byte (red 5:4, green 3:2, blue 1:0), and bits 7:6 have no effect.
- R5: The mode byte for band b is at address {3'b111, b as 6 bits, 7'b1011110}. It is read on the first blanking cycle (h = H_VIS) of the scanline before the band's first line; for band 0 that is the last line of the frame. The value 8'h01 selects image and any other value selects text. The choice holds for all 16 lines of the band, even if the byte changes while the band is being drawn.
- R6: `rgb_o` is 0 whenever the position is outside the visible H_VIS×V_VIS area.
- R7: The font contains these codes. 8'hDB sets every row to 8'hFF. 8'hDC sets rows 8–15 to 8'hFF and rows 0–7 to 0. 8'hDD sets every row to 8'hF0. 8'h41 and 8'h48 are letter shapes. Code 8'h20 and every code not listed are blank.
- R8: `mem_rd_en_o` is high exactly on visible-pixel cycles and on mode-fetch cycles, and low on all other cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Pixel clock |
| rst_i | input | 1 | Synchronous active-high reset |
| mem_rd_en_o | output | 1 | Video memory read request |
| mem_addr_o | output | 16 | Video memory read address |
| mem_rdata_i | input | 8 | Read data, valid one cycle after the request |
| hsync_o | output | 1 | Horizontal sync, active low |
| vsync_o | output | 1 | Vertical sync, active low |
| rgb_o | output | 6 | Pixel colour {r[1:0], g[1:0], b[1:0]} |

## Verification
The hardest case to reach from the ports is a mode byte that changes while its own band is on screen. The renderer must ignore that change until the fetch on the line before the band comes round again in the next frame. The bench rewrites band 1's mode byte in the middle of band 1 and band 2's mode byte before band 2 begins. It changes band 0's mode byte during vertical blanking, and once writes a non-unit value that must fall back to text. Its cycle model fetches the mode byte only at the specified blanking cycle, so a renderer that reacts too early or too late shows up as a colour mismatch at a band edge.

// File: rtl/vmr_pkg.sv
package vmr_pkg;
  localparam int ADDR_W = 16;
  localparam int DATA_W = 8;
  localparam int RGB_W  = 6;

  typedef enum logic {
    MODE_TEXT  = 1'b0,
    MODE_IMAGE = 1'b1
  } band_mode_e;

  localparam logic [2:0]        TEXT_PREFIX = 3'b111;
  localparam logic [6:0]        MODE_COLUMN = 7'd94;
  localparam logic [DATA_W-1:0] IMAGE_CODE  = 8'h01;
endpackage

// File: rtl/vmr_timing.sv
module vmr_timing #(
  parameter int H_VIS  = 640,
  parameter int H_FP   = 16,
  parameter int H_SYNC = 96,
  parameter int H_BP   = 48,
  parameter int V_VIS  = 480,
  parameter int V_FP   = 10,
  parameter int V_SYNC = 2,
  parameter int V_BP   = 33,
  parameter int H_W    = 10,
  parameter int V_W    = 10
) (
  input  logic           clk_i,
  input  logic           rst_i,
  output logic [H_W-1:0] h_o,
  output logic [V_W-1:0] v_o,
  output logic           vis_o,
  output logic           hs_n_o,
  output logic           vs_n_o,
  output logic           fetch_o,
  output logic [5:0]     fetch_band_o
);
  localparam int H_TOT = H_VIS + H_FP + H_SYNC + H_BP;
  localparam int V_TOT = V_VIS + V_FP + V_SYNC + V_BP;
  localparam logic [H_W-1:0] HL_LAST = H_W'(H_TOT - 1);
  localparam logic [H_W-1:0] HL_VIS  = H_W'(H_VIS);
  localparam logic [H_W-1:0] HL_SS   = H_W'(H_VIS + H_FP);
  localparam logic [H_W-1:0] HL_SE   = H_W'(H_VIS + H_FP + H_SYNC);
  localparam logic [V_W-1:0] VL_LAST = V_W'(V_TOT - 1);
  localparam logic [V_W-1:0] VL_VIS  = V_W'(V_VIS);
  localparam logic [V_W-1:0] VL_SS   = V_W'(V_VIS + V_FP);
  localparam logic [V_W-1:0] VL_SE   = V_W'(V_VIS + V_FP + V_SYNC);

  logic [V_W-1:0] next_v;

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      h_o <= '0;
      v_o <= '0;
    end else if (h_o == HL_LAST) begin
      h_o <= '0;
      v_o <= next_v;
    end else begin
      h_o <= h_o + 1'b1;
    end
  end

  always_comb begin
    next_v       = (v_o == VL_LAST) ? '0 : v_o + 1'b1;
    vis_o        = (h_o < HL_VIS) && (v_o < VL_VIS);
    hs_n_o       = !((h_o >= HL_SS) && (h_o < HL_SE));
    vs_n_o       = !((v_o >= VL_SS) && (v_o < VL_SE));
    fetch_o      = (h_o == HL_VIS) && (next_v < VL_VIS) && (next_v[3:0] == 4'd0);
    fetch_band_o = 6'(next_v >> 4);
  end
endmodule

// File: rtl/vmr_addr.sv
module vmr_addr import vmr_pkg::*; #(
  parameter int H_W = 10,
  parameter int V_W = 10
) (
  input  logic [H_W-1:0]    h_i,
  input  logic [V_W-1:0]    v_i,
  input  band_mode_e        mode_i,
  input  logic              fetch_i,
  input  logic [5:0]        fetch_band_i,
  output logic [ADDR_W-1:0] addr_o
);
  logic [6:0] cell_col;
  logic [5:0] cell_row;
  logic [7:0] img_x;
  logic [6:0] img_y;

  always_comb begin
    cell_col = 7'(h_i >> 3);
    cell_row = 6'(v_i >> 4);
    img_x    = 8'(h_i >> 2);
    img_y    = 7'(v_i >> 2);
    if (fetch_i)
      addr_o = {TEXT_PREFIX, fetch_band_i, MODE_COLUMN};
    else if (mode_i == MODE_IMAGE)
      addr_o = {1'b1, img_x, img_y};
    else
      addr_o = {TEXT_PREFIX, cell_row, cell_col};
  end
endmodule

// File: rtl/vmr_font.sv
module vmr_font (
  input  logic [7:0] code_i,
  input  logic [3:0] row_i,
  output logic [7:0] bits_o
);
  logic body;
  logic bar;

  always_comb begin
    body = (row_i >= 4'd2) && (row_i <= 4'd13);
    bar  = (row_i == 4'd7) || (row_i == 4'd8);
    unique case (code_i)
      8'hDB: bits_o = 8'hFF;
      8'hDC: bits_o = row_i[3] ? 8'hFF : 8'h00;
      8'hDD: bits_o = 8'hF0;
      8'h48: bits_o = !body ? 8'h00 : (bar ? 8'hFF : 8'hC3);
      8'h41: begin
        unique case (row_i)
          4'd2:          bits_o = 8'h18;
          4'd3:          bits_o = 8'h3C;
          4'd4:          bits_o = 8'h66;
          4'd8, 4'd9:    bits_o = 8'hFF;
          4'd5, 4'd6, 4'd7, 4'd10, 4'd11, 4'd12, 4'd13:
                         bits_o = 8'hC3;
          default:       bits_o = 8'h00;
        endcase
      end
      default: bits_o = 8'h00;
    endcase
  end
endmodule

// File: rtl/vga_mixed_renderer.sv
module vga_mixed_renderer import vmr_pkg::*; #(
  parameter int COLS   = 80,
  parameter int ROWS   = 30,
  parameter int H_FP   = 16,
  parameter int H_SYNC = 96,
  parameter int H_BP   = 48,
  parameter int V_FP   = 10,
  parameter int V_SYNC = 2,
  parameter int V_BP   = 33
) (
  input  logic              clk_i,
  input  logic              rst_i,
  output logic              mem_rd_en_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  input  logic [DATA_W-1:0] mem_rdata_i,
  output logic              hsync_o,
  output logic              vsync_o,
  output logic [RGB_W-1:0]  rgb_o
);
  localparam int H_VIS = COLS * 8;
  localparam int V_VIS = ROWS * 16;
  localparam int H_TOT = H_VIS + H_FP + H_SYNC + H_BP;
  localparam int V_TOT = V_VIS + V_FP + V_SYNC + V_BP;
  localparam int H_W   = $clog2(H_TOT);
  localparam int V_W   = $clog2(V_TOT);

  // stage 0: scan position and request
  logic [H_W-1:0] h_cnt;
  logic [V_W-1:0] v_cnt;
  logic           vis0, hs0_n, vs0_n, fetch0;
  logic [5:0]     fetch_band0;
  band_mode_e     mode_q;

  vmr_timing #(
    .H_VIS(H_VIS), .H_FP(H_FP), .H_SYNC(H_SYNC), .H_BP(H_BP),
    .V_VIS(V_VIS), .V_FP(V_FP), .V_SYNC(V_SYNC), .V_BP(V_BP),
    .H_W(H_W), .V_W(V_W)
  ) u_timing (
    .clk_i(clk_i), .rst_i(rst_i), .h_o(h_cnt), .v_o(v_cnt),
    .vis_o(vis0), .hs_n_o(hs0_n), .vs_n_o(vs0_n),
    .fetch_o(fetch0), .fetch_band_o(fetch_band0)
  );

  vmr_addr #(.H_W(H_W), .V_W(V_W)) u_addr (
    .h_i(h_cnt), .v_i(v_cnt), .mode_i(mode_q), .fetch_i(fetch0),
    .fetch_band_i(fetch_band0), .addr_o(mem_addr_o)
  );

  assign mem_rd_en_o = vis0 | fetch0;

  // stage 1: memory data returns, glyph lookup
  logic       vis1, hs1_n, vs1_n, fetch1;
  logic [3:0] row1;
  logic [2:0] bit1;
  logic [7:0] glyph;
  logic [RGB_W-1:0] pix1;

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      vis1   <= 1'b0;
      hs1_n  <= 1'b1;
      vs1_n  <= 1'b1;
      fetch1 <= 1'b0;
      row1   <= '0;
      bit1   <= '0;
    end else begin
      vis1   <= vis0;
      hs1_n  <= hs0_n;
      vs1_n  <= vs0_n;
      fetch1 <= fetch0;
      row1   <= v_cnt[3:0];
      bit1   <= h_cnt[2:0];
    end
  end

  vmr_font u_font (.code_i(mem_rdata_i), .row_i(row1), .bits_o(glyph));

  always_comb begin
    if (mode_q == MODE_IMAGE)
      pix1 = mem_rdata_i[RGB_W-1:0];
    else
      pix1 = glyph[3'd7 - bit1] ? {RGB_W{1'b1}} : '0;
  end

  always_ff @(posedge clk_i) begin
    if (rst_i)
      mode_q <= MODE_TEXT;
    else if (fetch1)
      mode_q <= (mem_rdata_i == IMAGE_CODE) ? MODE_IMAGE : MODE_TEXT;
  end

  // stage 2: registered video outputs
  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      hsync_o <= 1'b1;
      vsync_o <= 1'b1;
      rgb_o   <= '0;
    end else begin
      hsync_o <= hs1_n;
      vsync_o <= vs1_n;
      rgb_o   <= vis1 ? pix1 : '0;
    end
  end
endmodule

// File: rtl/vmr_checker.sv
module vmr_checker #(
  parameter int H_W    = 10,
  parameter int H_VIS  = 640,
  parameter int H_SYNC = 96
) (
  input logic           clk_i,
  input logic           rst_i,
  input logic           hsync_o,
  input logic           vsync_o,
  input logic [5:0]     rgb_o,
  input logic           mem_rd_en_o,
  input logic           mode_q,
  input logic [H_W-1:0] h_cnt
);
  logic [15:0] low_run;

  always_ff @(posedge clk_i) begin
    if (rst_i)         low_run <= '0;
    else if (!hsync_o) low_run <= low_run + 1'b1;
    else               low_run <= '0;
  end

  AST_HSYNC_WIDTH: assert property (@(posedge clk_i) disable iff (rst_i)
    $rose(hsync_o) |-> (low_run == 16'(H_SYNC)));                          // R1
  AST_BLANK_BLACK: assert property (@(posedge clk_i) disable iff (rst_i)
    (!hsync_o || !vsync_o) |-> (rgb_o == 6'd0));                           // R6
  AST_NO_READ_IN_SYNC: assert property (@(posedge clk_i) disable iff (rst_i)
    !hsync_o |-> !mem_rd_en_o);                                            // R8
  AST_MODE_AT_FETCH: assert property (@(posedge clk_i) disable iff (rst_i)
    !$stable(mode_q) |-> ($past(h_cnt) == H_W'(H_VIS + 1)));               // R5
endmodule

bind vga_mixed_renderer vmr_checker #(
  .H_W(H_W), .H_VIS(H_VIS), .H_SYNC(H_SYNC)
) u_vmr_checker (
  .clk_i(clk_i), .rst_i(rst_i), .hsync_o(hsync_o), .vsync_o(vsync_o),
  .rgb_o(rgb_o), .mem_rd_en_o(mem_rd_en_o), .mode_q(mode_q), .h_cnt(h_cnt)
);

// File: tb/test_vga_mixed_renderer.sv
`timescale 1ns/1ps
module test_vga_mixed_renderer;
  localparam int COLS = 8, ROWS = 3;
  localparam int HFP = 4, HSY = 8, HBP = 4, VFP = 2, VSY = 2, VBP = 3;
  localparam int HV = COLS * 8, VV = ROWS * 16;
  localparam int HT = HV + HFP + HSY + HBP, VT = VV + VFP + VSY + VBP;
  localparam int TXT = 57344, IMG = 32768;

  typedef struct { logic hs; logic vs; logic [5:0] rgb; int tag; } exp_t;

  logic clk = 1'b0, rst = 1'b1;
  logic rd_en, hsync, vsync;
  logic [15:0] addr;
  logic [7:0] rdata = 8'h00;
  logic [5:0] rgb;
  logic [7:0] mem [0:65535];

  int checks = 0, fails = 0;
  int mh = 0, mv = 0, cur_mode = 0;
  bit run = 1'b0, done = 1'b0;
  exp_t q[$];

  always #5 clk = ~clk;

  vga_mixed_renderer #(.COLS(COLS), .ROWS(ROWS), .H_FP(HFP), .H_SYNC(HSY),
    .H_BP(HBP), .V_FP(VFP), .V_SYNC(VSY), .V_BP(VBP)) i_vga_mixed_renderer (
    .clk_i(clk), .rst_i(rst), .mem_rd_en_o(rd_en), .mem_addr_o(addr),
    .mem_rdata_i(rdata), .hsync_o(hsync), .vsync_o(vsync), .rgb_o(rgb));

  always @(posedge clk) if (rd_en) rdata <= mem[addr];

  function automatic logic [7:0] glyph_row(input logic [7:0] c, input int r);
    if (c == 8'hDB) return 8'hFF;
    if (c == 8'hDC) return (r >= 8) ? 8'hFF : 8'h00;
    if (c == 8'hDD) return 8'hF0;
    return 8'h00;
  endfunction

  function automatic string tag_name(input int t);
    case (t)
      3: return "R2 R3 R5 R7 text";
      4: return "R2 R4 R5 image";
      default: return "R2 R6 blank";
    endcase
  endfunction

  function automatic exp_t model(input int h, input int v);
    exp_t e;
    logic [7:0] b;
    e.hs = !(h >= HV + HFP && h < HV + HFP + HSY);
    e.vs = !(v >= VV + VFP && v < VV + VFP + VSY);
    e.rgb = 6'd0;
    e.tag = 6;
    if (h < HV && v < VV) begin
      if (cur_mode != 0) begin
        b = mem[IMG + (h / 4) * 128 + v / 4];
        e.rgb = b[5:0];
        e.tag = 4;
      end else begin
        b = glyph_row(mem[TXT + (v / 16) * 128 + h / 8], v % 16);
        e.rgb = b[7 - h % 8] ? 6'h3F : 6'h00;
        e.tag = 3;
      end
    end
    return e;
  endfunction

  always @(negedge clk) begin
    if (run && !done) begin
      exp_t cur, old;
      int nv;
      bit fetch, erd;
      nv = (mv == VT - 1) ? 0 : mv + 1;
      fetch = (mh == HV) && (nv < VV) && (nv % 16 == 0);
      erd = (mh < HV && mv < VV) || fetch;
      cur = model(mh, mv);
      q.push_back(cur);
      old = q.pop_front();
      checks++;
      if (hsync !== old.hs || vsync !== old.vs) begin
        fails++;
        $display("FAIL R1: sync actual %b%b expected %b%b", hsync, vsync, old.hs, old.vs);
      end
      checks++;
      if (rgb !== old.rgb) begin
        fails++;
        $display("FAIL %s: rgb actual %h expected %h (scan %0d,%0d)",
                 tag_name(old.tag), rgb, old.rgb, mh, mv);
      end
      checks++;
      if (rd_en !== erd) begin
        fails++;
        $display("FAIL R8: rd_en actual %b expected %b", rd_en, erd);
      end
      if (fetch) cur_mode = (mem[TXT + (nv / 16) * 128 + 94] == 8'h01) ? 1 : 0; // R5
      if (mh == HT - 1) begin mh = 0; mv = nv; end else mh = mh + 1;
    end
  end

  task automatic wait_scan(input int h, input int v);
    forever begin
      @(posedge clk); #1;
      if (mh == h && mv == v) break;
    end
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    exp_t r0;
    byte codes [5] = '{8'h20, 8'hDB, 8'hDC, 8'hDD, 8'h7E};
    for (int i = 0; i < 65536; i++) mem[i] = 8'h00;
    for (int r = 0; r < ROWS; r++)
      for (int c = 0; c < COLS; c++)
        mem[TXT + r * 128 + c] = codes[(r * 3 + c) % 5];
    for (int x = 0; x < HV / 4; x++)
      for (int y = 0; y < VV / 4; y++)
        mem[IMG + x * 128 + y] = 8'((x * 5 + y * 3) & 63) | ((x & 1) ? 8'hC0 : 8'h00);
    mem[TXT + 0 * 128 + 94] = 8'h00;
    mem[TXT + 1 * 128 + 94] = 8'h01;
    mem[TXT + 2 * 128 + 94] = 8'h02;
    repeat (4) @(negedge clk);
    checks++;  // R2 reset state
    if (hsync !== 1'b1 || vsync !== 1'b1 || rgb !== 6'd0) begin
      fails++;
      $display("FAIL R2: reset outputs actual %b%b %h expected 11 00", hsync, vsync, rgb);
    end
    r0.hs = 1'b1; r0.vs = 1'b1; r0.rgb = 6'd0; r0.tag = 6;
    q.push_back(r0); q.push_back(r0);
    @(posedge clk); #1;
    rst = 1'b0;
    run = 1'b1;
    // R5: band 1 byte changes mid-band, band 2 byte before its fetch
    wait_scan(HV + 4, 20);
    mem[TXT + 1 * 128 + 94] = 8'h00;
    mem[TXT + 2 * 128 + 94] = 8'h01;
    // frame 1: band 0 becomes image during vertical blanking
    wait_scan(0, VV + 1);
    mem[TXT + 0 * 128 + 94] = 8'h01;
    mem[TXT + 4] = 8'hDD;
    // frame 2: non-unit value falls back to text; pixel high bits change (R4)
    wait_scan(0, VV + 1);
    mem[TXT + 0 * 128 + 94] = 8'h81;
    mem[TXT + 2 * 128 + 94] = 8'h00;
    mem[TXT + 1 * 128 + 94] = 8'h01;
    for (int x = 0; x < HV / 4; x++) mem[IMG + x * 128 + 5] = 8'hF0 | 8'(x & 15);
    wait_scan(0, VV + 1);
    wait_scan(10, VV + 2);
    done = 1'b1;
    summary();
  end

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: run did not finish, actual timeout expected completion");
    done = 1'b1;
    summary();
  end
endmodule